// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog counter. It asks for a system reset when software stops servicing it. The counter advances by one on every cycle in which `tick_en` is high. When it has advanced `period` times since the last clear or timeout, it raises a timeout, sets a sticky timeout flag and starts again from zero. The counter can be cleared in one of two ways, picked by a bit in the control word: a one-cycle software strobe, or a rising edge on an external trigger pin. The trigger pin is synchronized first and then edge-detected.

The block can also catch a service that comes too early. A 3-bit window field `n` defines an early limit of `(period >> 3) * n` counts. A clear that arrives while the count is still below that limit is a window fault. The fault sets its own sticky flag, clears the counter and raises a reset request. A control bit can suppress the reset request for both kinds of fault, and the flags are still recorded when it does.

A small state machine turns each event into a one-cycle output.
- `ST_RUN` is the normal counting state.
- `ST_RUN -> ST_EXPIRE` is taken on a timeout.
- `ST_RUN -> ST_BADCLR` is taken on an early clear.
- From either event state the machine goes back to `ST_RUN` after one cycle. It can also go straight to the other event state if a new event arrives in that cycle.

The reset request is high only while the machine is in `ST_EXPIRE` or `ST_BADCLR`.

Top module: `wdt_window_top`

## Requirements
- R1: After reset, the following are all zero: `ctrl_rdata`, both flags, `rst_req` and the internal count.
- R2: The control word uses three fields:
  - bit 31 is the reset-disable bit;
  - bit 30 is the clear source (0 = software strobe, 1 = external edge);
  - bits 26:24 are the window select.
  
  Every other bit reads as zero, and writes to those bits have no effect. All three fields reset to zero.
- R3: Each cycle with `tick_en` high adds one to the count. A tick that would bring the count to `period` is a timeout: it sets the timeout flag on that clock edge and restarts the count at zero. With ticks every cycle and a period of P, a timeout comes P cycles after the clear edge.
- R4: A timeout or a window fault drives `rst_req` high for exactly the cycle after the event edge, provided bit 31 is 0. When bit 31 is 1, `rst_req` stays low.
- R5: With bit 30 = 0, a high `sw_clear` at a clock edge zeroes the count, and activity on `ext_trig` has no effect.
- R6: With bit 30 = 1, a 0-to-1 change on `ext_trig` zeroes the count at the third clock edge that samples the new level. A level held high clears only once. `sw_clear` has no effect.
- R7: With window select n between 1 and 7, the early limit is `(period >> 3) * n`.
  - A clear seen while the count is below that limit is a window fault: it sets the window-fault flag, zeroes the count and requests reset as in R4.
  - A clear at a count equal to or above the limit is legal.
  - With n = 0, no clear is ever a fault.
- R8: The two flags stay set until `flag_clr_we` is high with a 1 in the matching mask bit (bit 0 = timeout, bit 1 = window fault). A flag being set at the same edge as its clear stays set.
- R9: A clear and a would-be timeout at the same edge count as a clear only: no timeout, no flag, no reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable for this cycle |
| period | input | CNT_W | Timeout length in ticks |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write data |
| ctrl_rdata | output | 32 | Control word read-back |
| sw_clear | input | 1 | Software clear strobe |
| ext_trig | input | 1 | External clear trigger (asynchronous) |
| flag_clr_we | input | 1 | Flag clear strobe |
| flag_clr_mask | input | 2 | Write-1-to-clear mask: bit 0 timeout, bit 1 window fault |
| rst_req | output | 1 | One-cycle reset request |
| timeout_flag | output | 1 | Sticky timeout flag |
| window_fault_flag | output | 1 | Sticky early-clear flag |

## Verification
The hardest cases to reach are the boundaries of the early window. The count is not visible at the ports, so the stimulus has to place a clear at exactly the count just below the limit and at exactly the count equal to it. The bench holds `tick_en` high from a known zero count and schedules each clear edge by cycle number. It does the same to make a clear coincide with the last tick before expiry, and to make a flag clear coincide with a flag set. The external path is driven through its synchronizer latency, and the level is then held high so that a second clear would show up as a missing timeout.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int CTRL_W    = 32;
    localparam int RDIS_BIT  = 31;
    localparam int SRC_BIT   = 30;
    localparam int WIN_LSB   = 24;
    localparam int WIN_W     = 3;
    localparam int WIN_FRACT = 3;   // limit unit is period >> WIN_FRACT

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_EXPIRE = 2'd1,
        ST_BADCLR = 2'd2
    } wdt_state_e;

    typedef struct packed {
        logic             rst_dis;
        logic             clr_src;
        logic [WIN_W-1:0] win;
    } wdt_cfg_t;

endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output wdt_cfg_t          cfg,
    output logic [CTRL_W-1:0] rdata
);

    wdt_cfg_t cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q.rst_dis <= wdata[RDIS_BIT];
            cfg_q.clr_src <= wdata[SRC_BIT];
            cfg_q.win     <= wdata[WIN_LSB +: WIN_W];
        end
    end

    always_comb begin
        rdata                  = '0;
        rdata[RDIS_BIT]        = cfg_q.rst_dis;
        rdata[SRC_BIT]         = cfg_q.clr_src;
        rdata[WIN_LSB +: WIN_W] = cfg_q.win;
    end

    assign cfg = cfg_q;

    // R2: a write lands in the window field on the next edge
    p_cfg_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cfg_q.win == $past(wdata[WIN_LSB +: WIN_W])));

endmodule

// File: rtl/wdt_trig_edge.sv
module wdt_trig_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic rise_o
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= trig_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[STAGES-1];
    end

    assign rise_o = sync_q[STAGES-1] & ~last_q;

    // R6: a held level yields a single-cycle edge event
    p_single_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] period,
    input  wdt_cfg_t         cfg,
    input  logic             sw_clr,
    input  logic             ext_rise,
    input  logic             flag_we,
    input  logic [1:0]       flag_mask,
    output logic             rst_req,
    output logic             to_flag,
    output logic             wf_flag
);

    localparam int LIM_W = CNT_W + WIN_W;

    wdt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [LIM_W-1:0] lim;
    logic             clr_evt, early, bad_evt, expire_evt;
    logic             to_flag_q, wf_flag_q;

    // window limit: (period >> 3) * n, shift-and-multiply by a 3-bit value
    assign lim = LIM_W'(period >> WIN_FRACT) * LIM_W'(cfg.win);

    // clear source selection; the unselected path is ignored
    assign clr_evt    = cfg.clr_src ? ext_rise : sw_clr;
    assign early      = (cfg.win != '0) && (LIM_W'(cnt_q) < lim);
    assign bad_evt    = clr_evt && early;
    assign expire_evt = !clr_evt && tick_en &&
                        ((CNT_W+1)'(cnt_q) + 1'b1 >= (CNT_W+1)'(period));

    // counter next value
    always_comb begin
        cnt_d = cnt_q;
        if (clr_evt)         cnt_d = '0;
        else if (expire_evt) cnt_d = '0;
        else if (tick_en)    cnt_d = cnt_q + 1'b1;
    end

    // next-state logic
    always_comb begin
        state_d = ST_RUN;
        unique case (state_q)
            ST_RUN, ST_EXPIRE, ST_BADCLR: begin
                if (expire_evt)   state_d = ST_EXPIRE;
                else if (bad_evt) state_d = ST_BADCLR;
                else              state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs: sticky flags (set wins) and the reset pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            to_flag_q <= 1'b0;
            wf_flag_q <= 1'b0;
        end else begin
            if (state_d == ST_EXPIRE)          to_flag_q <= 1'b1;
            else if (flag_we && flag_mask[0])  to_flag_q <= 1'b0;
            if (state_d == ST_BADCLR)          wf_flag_q <= 1'b1;
            else if (flag_we && flag_mask[1])  wf_flag_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_EXPIRE, ST_BADCLR: rst_req = !cfg.rst_dis;
            default:              rst_req = 1'b0;
        endcase
    end

    assign to_flag = to_flag_q;
    assign wf_flag = wf_flag_q;

    // R5: any selected clear leaves the count at zero
    p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_evt |=> (cnt_q == '0));

    // R3: an ordinary tick advances the count by one
    p_tick_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !clr_evt && ((CNT_W+1)'(cnt_q) + 1'b1 < (CNT_W+1)'(period)))
        |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R3: being in the expire state means the timeout flag is set
    p_expire_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXPIRE) |-> to_flag_q);

    // R8: the timeout flag holds until a write-1 clear
    p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (to_flag_q && !(flag_we && flag_mask[0])) |=> to_flag_q);

    // R7: a window fault leaves its flag set
    p_badclr_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BADCLR) |-> wf_flag_q);

endmodule

// File: rtl/wdt_window_top.sv
module wdt_window_top
    import wdt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] period,
    input  logic             ctrl_we,
    input  logic [31:0]      ctrl_wdata,
    output logic [31:0]      ctrl_rdata,
    input  logic             sw_clear,
    input  logic             ext_trig,
    input  logic             flag_clr_we,
    input  logic [1:0]       flag_clr_mask,
    output logic             rst_req,
    output logic             timeout_flag,
    output logic             window_fault_flag
);

    wdt_cfg_t cfg;
    logic     ext_rise;

    wdt_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctrl_we),
        .wdata (ctrl_wdata),
        .cfg   (cfg),
        .rdata (ctrl_rdata)
    );

    wdt_trig_edge #(.STAGES(SYNC_STAGES)) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (ext_trig),
        .rise_o  (ext_rise)
    );

    wdt_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .period    (period),
        .cfg       (cfg),
        .sw_clr    (sw_clear),
        .ext_rise  (ext_rise),
        .flag_we   (flag_clr_we),
        .flag_mask (flag_clr_mask),
        .rst_req   (rst_req),
        .to_flag   (timeout_flag),
        .wf_flag   (window_fault_flag)
    );

endmodule

// File: tb/sim_wdt_window_top.sv
module sim_wdt_window_top;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_en = 1'b0;
    logic [CNT_W-1:0] period = 16'd16;
    logic             ctrl_we = 1'b0;
    logic [31:0]      ctrl_wdata = '0;
    logic [31:0]      ctrl_rdata;
    logic             sw_clear = 1'b0;
    logic             ext_trig = 1'b0;
    logic             flag_clr_we = 1'b0;
    logic [1:0]       flag_clr_mask = '0;
    logic             rst_req, timeout_flag, window_fault_flag;

    always #5 clk = ~clk;

    wdt_window_top #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .period(period),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
        .sw_clear(sw_clear), .ext_trig(ext_trig),
        .flag_clr_we(flag_clr_we), .flag_clr_mask(flag_clr_mask),
        .rst_req(rst_req), .timeout_flag(timeout_flag),
        .window_fault_flag(window_fault_flag)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    int    exp_q[$];
    string tag_q[$];
    bit    done = 0;

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got=%h expected=%h (cycle %0d)", req, got, exp, cyc);
        end
    endtask

    // driver side of the scoreboard: expected reset pulse cycles
    task automatic expect_pulse(int c, string req);
        exp_q.push_back(c);
        tag_q.push_back(req);
    endtask

    // monitor side: compare every rst_req cycle against the queue
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (exp_q.size() > 0 && exp_q[0] < cyc) begin
                n_chk++; n_bad++;
                $display("FAIL %s: got=no pulse expected=pulse at cycle %0d", tag_q[0], exp_q[0]);
                void'(exp_q.pop_front()); void'(tag_q.pop_front());
            end
            if (rst_req) begin
                n_chk++;
                if (exp_q.size() > 0 && exp_q[0] == cyc) begin
                    void'(exp_q.pop_front()); void'(tag_q.pop_front());
                end else begin
                    n_bad++;
                    $display("FAIL R4: got=pulse at cycle %0d expected=no pulse", cyc);
                end
            end
        end
    end

    task automatic wait_to(int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic sw_at(int e);
        wait_to(e - 1); sw_clear = 1'b1;
        wait_to(e);     sw_clear = 1'b0;
    endtask

    task automatic wr_ctrl(logic [31:0] v);
        ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0; ctrl_wdata = '0;
    endtask

    task automatic clr_flags(logic [1:0] m);
        flag_clr_we = 1'b1; flag_clr_mask = m;
        @(negedge clk);
        flag_clr_we = 1'b0; flag_clr_mask = '0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got=hung expected=finish");
        done = 1;
        summary();
        $finish;
    end

    initial begin
        int t0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 rdata", ctrl_rdata, 32'h0);
        check("R1 timeout_flag", {31'b0, timeout_flag}, 32'h0);
        check("R1 window_fault_flag", {31'b0, window_fault_flag}, 32'h0);
        check("R1 rst_req", {31'b0, rst_req}, 32'h0);

        // R2 field layout, reserved bits ignored
        wr_ctrl(32'hFFFF_FFFF);
        check("R2 all-ones readback", ctrl_rdata, 32'hC700_0000);
        wr_ctrl(32'h3A5A_5A5A);
        check("R2 mixed readback", ctrl_rdata, 32'h0200_0000);
        wr_ctrl(32'h0);
        check("R2 zero readback", ctrl_rdata, 32'h0);

        // R3/R4/R8: periodic timeouts, flag write-1 clear, set wins
        t0 = cyc + 1; tick_en = 1'b1;
        expect_pulse(t0 + 15, "R3");
        expect_pulse(t0 + 31, "R3");
        wait_to(t0 + 16);
        check("R3 timeout flag set", {31'b0, timeout_flag}, 32'h1);
        check("R7 n=0 no fault", {31'b0, window_fault_flag}, 32'h0);
        wait_to(t0 + 18); flag_clr_we = 1'b1; flag_clr_mask = 2'b01;
        wait_to(t0 + 19); flag_clr_we = 1'b0; flag_clr_mask = 2'b00;
        wait_to(t0 + 20);
        check("R8 write-1 clears timeout", {31'b0, timeout_flag}, 32'h0);
        wait_to(t0 + 30); flag_clr_we = 1'b1; flag_clr_mask = 2'b01;
        wait_to(t0 + 31); flag_clr_we = 1'b0; flag_clr_mask = 2'b00; tick_en = 1'b0;
        wait_to(t0 + 32);
        check("R8 set wins over clear", {31'b0, timeout_flag}, 32'h1);

        // R4 reset disabled: flag but no pulse
        clr_flags(2'b01);
        wr_ctrl(32'h8000_0000);
        t0 = cyc + 1; tick_en = 1'b1;
        wait_to(t0 + 15); tick_en = 1'b0;
        check("R4 flag with reset disabled", {31'b0, timeout_flag}, 32'h1);

        // R5 software source: ext edges ignored
        wr_ctrl(32'h0);
        t0 = cyc + 1; tick_en = 1'b1;
        expect_pulse(t0 + 15, "R5");
        wait_to(t0 + 3);  ext_trig = 1'b1;
        wait_to(t0 + 8);  ext_trig = 1'b0;
        wait_to(t0 + 15); tick_en = 1'b0;

        // R6 external source: sw ignored, one clear per rising edge
        wr_ctrl(32'h4000_0000);
        t0 = cyc + 1; tick_en = 1'b1;
        expect_pulse(t0 + 26, "R6");
        expect_pulse(t0 + 42, "R6");
        sw_at(t0 + 5);
        wait_to(t0 + 7);  ext_trig = 1'b1;
        wait_to(t0 + 42); tick_en = 1'b0;
        wait_to(t0 + 43); ext_trig = 1'b0;
        check("R6 rdata source bit", ctrl_rdata, 32'h4000_0000);

        // R7 window n=4 (limit 8): counts 5 and 7 illegal, 8 legal
        wr_ctrl(32'h0400_0000);
        clr_flags(2'b11);
        t0 = cyc + 1; tick_en = 1'b1;
        expect_pulse(t0 + 5,  "R7");
        expect_pulse(t0 + 13, "R7");
        expect_pulse(t0 + 38, "R7");
        sw_at(t0 + 5);
        wait_to(t0 + 6);
        check("R7 early clear sets fault", {31'b0, window_fault_flag}, 32'h1);
        sw_at(t0 + 13);
        sw_at(t0 + 22);
        wait_to(t0 + 38); tick_en = 1'b0;
        clr_flags(2'b10);
        check("R8 fault flag cleared", {31'b0, window_fault_flag}, 32'h0);
        check("R8 timeout flag untouched", {31'b0, timeout_flag}, 32'h1);

        // R7 + R4: n=7 (limit 14), reset disabled
        clr_flags(2'b11);
        wr_ctrl(32'h8700_0000);
        t0 = cyc + 1; tick_en = 1'b1;
        sw_at(t0 + 13);
        wait_to(t0 + 14);
        check("R7 count 13 below 14 faults", {31'b0, window_fault_flag}, 32'h1);
        sw_at(t0 + 28);
        wait_to(t0 + 29);
        check("R7 no timeout yet", {31'b0, timeout_flag}, 32'h0);
        wait_to(t0 + 30); tick_en = 1'b0;

        // R9 clear wins over timeout at the same edge
        wr_ctrl(32'h0);
        sw_clear = 1'b1; @(negedge clk); sw_clear = 1'b0;
        clr_flags(2'b11);
        t0 = cyc + 1; tick_en = 1'b1;
        expect_pulse(t0 + 31, "R9");
        sw_at(t0 + 15);
        wait_to(t0 + 16);
        check("R9 no timeout on clear edge", {31'b0, timeout_flag}, 32'h0);
        wait_to(t0 + 31); tick_en = 1'b0;
        wait_to(t0 + 33);
        check("R9 later timeout", {31'b0, timeout_flag}, 32'h1);

        wait_to(cyc + 4);
        check("R4 all expected pulses seen", exp_q.size(), 32'h0);
        done = 1;
        summary();
        $finish;
    end

endmodule